// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one general-purpose I/O port of up to eight pins. A host reaches it through four registers chosen by a two-bit address. The output latch, the direction mask and the drive-mode mask can all be written and read back. A fourth register is read-only and returns the level seen on each pin. Bit n of every register belongs to pin n.

Programmable logic beside the port has two ways to take part. It can replace the output latch on chosen pins with its own data, through a per-pin enable mask and a data vector. It can also turn a pin into an output through a per-pin output-enable term. A pin drives whenever its direction bit or its output-enable term is set. In open-drain mode a pin actively pulls low and releases the line instead of driving a 1.

The pin inputs pass through a synchronizer of two flops before the host can read them. A parameter sets how many low-order pins are present. With three pins, as in the reduced port, the upper pins never drive and their register bits stay 0.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and right after it, the output latch, direction and drive-mode registers hold 0. Every pin is therefore an input (`pin_oe` = 0, `pin_out` = 0), and `drv_sel` = 0.
- R2: A write with `reg_wr` high at a rising clock edge loads `reg_wdata` into the register at `reg_addr`. Address 1 is the output latch, 2 is direction and 3 is drive mode. A read at the same address afterwards returns the value written.
- R3: Address 0 returns the pin levels. A change on `pin_in` shows there after the second rising edge, not after the first. A write to address 0 changes no register and no pin.
- R4: A pin drives (`pin_oe` = 1) when its direction bit is 1 or its `pl_oe` bit is 1. It is an input only when both are 0.
- R5: When `pl_ovr_en[n]` is 1, the value of pin n comes from `pl_ovr_data[n]`, otherwise from the output-latch bit. A host write to an overridden latch bit is still stored and read back, but it does not change the pin.
- R6: A drive-mode bit of 1 selects open drain. A driving pin whose value is 0 has `pin_oe` = 1 and `pin_out` = 0. A value of 1 releases the pin (`pin_oe` = 0). A drive-mode bit of 0 selects push-pull, where `pin_out` carries the value.
- R7: With `ACTIVE_PINS` below `PORT_W`, the upper bits read back 0 at every address and ignore writes. Their `pin_oe`, `pin_out` and `drv_sel` stay 0 whatever the inputs.
- R8: `drv_sel` presents the drive-mode register at all times, so the pad ring can set its slew rate from it.
- R9: `reg_rdata` is combinational from `reg_addr` while `reg_rd` is high, and it is 0 while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| reg_addr | input | 2 | Register select: 0 pin levels, 1 output latch, 2 direction, 3 drive mode |
| reg_wr | input | 1 | Write strobe, applied at the rising edge |
| reg_rd | input | 1 | Read strobe, gates `reg_rdata` |
| reg_wdata | input | PORT_W | Write data |
| reg_rdata | output | PORT_W | Read data, combinational |
| pl_ovr_en | input | PORT_W | Per-pin mask that hands the output value to programmable logic |
| pl_ovr_data | input | PORT_W | Output value used on overridden pins |
| pl_oe | input | PORT_W | Per-pin output-enable term from programmable logic |
| pin_in | input | PORT_W | Levels sensed on the pins |
| pin_out | output | PORT_W | Value driven onto each pin |
| pin_oe | output | PORT_W | Per-pin tri-state enable, 1 = drive |
| drv_sel | output | PORT_W | Drive-mode bits for the pad ring (open drain or slew) |

## Verification
The bench builds two copies side by side from the same stimulus. The first has the default full port of eight active pins. The second has `ACTIVE_PINS` = 3, so the masking of the five dead bits on reads, writes and pin outputs can be compared directly against the full port under identical input. Both use two synchronizer stages, which makes the one-edge and two-edge sample points of the pin levels fixed and checkable.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_LEVEL = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_MODE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int ACTIVE_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] mode_q
);

  localparam logic [PORT_W-1:0] LIVE = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_PINS);

  logic [PORT_W-1:0] latch_d, dir_d, mode_d;
  logic              latch_en, dir_en, mode_en;

  // clock enables, one per register
  always_comb begin
    latch_en = 1'b0;
    dir_en   = 1'b0;
    mode_en  = 1'b0;
    if (wr_en) begin
      unique case (reg_sel_e'(addr))
        REG_LATCH: latch_en = 1'b1;
        REG_DIR:   dir_en   = 1'b1;
        REG_MODE:  mode_en  = 1'b1;
        default:   ;
      endcase
    end
  end

  // next state
  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    mode_d  = mode_q;
    if (latch_en) latch_d = wdata & LIVE;
    if (dir_en)   dir_d   = wdata & LIVE;
    if (mode_en)  mode_d  = wdata & LIVE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      mode_q  <= '0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (dir_en)   dir_q   <= dir_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  // R1: registers are clear while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (latch_q == '0 && dir_q == '0 && mode_q == '0)
        else $error("config register not clear in reset");
    end
  end

  // R2: a direction write lands on the next edge
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (dir_q == ($past(wdata) & LIVE)));

  // R2: a latch write lands on the next edge
  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (latch_q == ($past(wdata) & LIVE)));

  // R3: no write (or a write to the level address) leaves everything untouched
  assert_level_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || addr == 2'd0) |=> ($stable(latch_q) && $stable(dir_q) && $stable(mode_q)));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int PORT_W      = 8,
  parameter int ACTIVE_PINS = 8,
  parameter int STAGES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] level_q
);

  localparam logic [PORT_W-1:0] LIVE = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_PINS);

  logic [PORT_W-1:0] stg_q [STAGES];
  logic [PORT_W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb stg_d[s] = pin_in & LIVE;
    end else begin : g_tail
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign level_q = stg_q[STAGES-1];

  // settle counter: cycles since reset, saturating at two
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_lat_chk
    // R3: the readable level is the pin value from two edges earlier
    assert_level_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (level_q == ($past(pin_in, 2) & LIVE)));
  end

endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
  parameter int PORT_W      = 8,
  parameter int ACTIVE_PINS = 8
) (
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] mode_q,
  input  logic [PORT_W-1:0] ovr_en,
  input  logic [PORT_W-1:0] ovr_data,
  input  logic [PORT_W-1:0] ext_oe,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);

  localparam logic [PORT_W-1:0] LIVE = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_PINS);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic value;
    logic want_drive;
    logic open_drain;

    always_comb begin
      value      = ovr_en[i] ? ovr_data[i] : latch_q[i];
      want_drive = (dir_q[i] | ext_oe[i]) & LIVE[i];
      open_drain = mode_q[i];
      if (open_drain) begin
        pin_oe[i]  = want_drive & ~value;
        pin_out[i] = 1'b0;
      end else begin
        pin_oe[i]  = want_drive;
        pin_out[i] = value & LIVE[i];
      end
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int ACTIVE_PINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] pl_ovr_en,
  input  logic [PORT_W-1:0] pl_ovr_data,
  input  logic [PORT_W-1:0] pl_oe,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] drv_sel
);

  localparam logic [PORT_W-1:0] LIVE = {PORT_W{1'b1}} >> (PORT_W - ACTIVE_PINS);

  logic [PORT_W-1:0] latch_q, dir_q, mode_q, level_q;

  gpio_port_regs #(.PORT_W(PORT_W), .ACTIVE_PINS(ACTIVE_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .mode_q  (mode_q)
  );

  gpio_port_sync #(.PORT_W(PORT_W), .ACTIVE_PINS(ACTIVE_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .level_q (level_q)
  );

  gpio_port_pad #(.PORT_W(PORT_W), .ACTIVE_PINS(ACTIVE_PINS)) u_pad (
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .mode_q   (mode_q),
    .ovr_en   (pl_ovr_en),
    .ovr_data (pl_ovr_data),
    .ext_oe   (pl_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  assign drv_sel = mode_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_sel_e'(reg_addr))
        REG_LEVEL: reg_rdata = level_q;
        REG_LATCH: reg_rdata = latch_q;
        REG_DIR:   reg_rdata = dir_q;
        REG_MODE:  reg_rdata = mode_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R4: push-pull pins drive exactly when direction or the external term asks
  assert_drive_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~drv_sel) == ((dir_q | pl_oe) & LIVE & ~drv_sel)));

  // R5: a driving push-pull pin carries override data or the latch
  assert_value_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~drv_sel & (pin_out ^ ((pl_ovr_en & pl_ovr_data) | (~pl_ovr_en & latch_q)))) == '0));

  // R6: an open-drain pin never drives a high level
  assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & drv_sel & pin_out) == '0));

  // R7: dead pins stay quiet and read back zero
  assert_dead_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_oe | pin_out | drv_sel | reg_rdata) & ~LIVE) == '0));

  // R9: no read strobe, no read data
  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] pl_ovr_en = '0, pl_ovr_data = '0, pl_oe = '0, pin_in = '0;
  logic [W-1:0] rdata0, pout0, poe0, drv0;
  logic [W-1:0] rdata1, pout1, poe1, drv1;

  always #2 clk = ~clk;  // 250 MHz

  gpio_port #(.PORT_W(W), .ACTIVE_PINS(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .pl_ovr_en(pl_ovr_en),
    .pl_ovr_data(pl_ovr_data), .pl_oe(pl_oe), .pin_in(pin_in),
    .pin_out(pout0), .pin_oe(poe0), .drv_sel(drv0));

  gpio_port #(.PORT_W(W), .ACTIVE_PINS(3), .SYNC_STAGES(2)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .pl_ovr_en(pl_ovr_en),
    .pl_ovr_data(pl_ovr_data), .pl_oe(pl_oe), .pin_in(pin_in),
    .pin_out(pout1), .pin_oe(poe1), .drv_sel(drv1));

  localparam logic [W-1:0] M0 = 8'hFF;
  localparam logic [W-1:0] M1 = 8'h07;

  int total = 0;
  int bad = 0;

  // unmasked model of the host-visible registers and settled pin levels
  logic [W-1:0] m_latch = '0, m_dir = '0, m_mode = '0, m_pins = '0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_oe(input logic [W-1:0] m);
    logic [W-1:0] val, want;
    val  = (pl_ovr_en & pl_ovr_data) | (~pl_ovr_en & m_latch);
    want = (m_dir | pl_oe) & m;
    return (want & ~m_mode) | (want & m_mode & ~val);
  endfunction

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] m);
    logic [W-1:0] val;
    val = (pl_ovr_en & pl_ovr_data) | (~pl_ovr_en & m_latch);
    return val & ~m_mode & m;
  endfunction

  function automatic logic [W-1:0] exp_reg(input logic [1:0] a, input logic [W-1:0] m);
    case (a)
      2'd0:    return m_pins & m;
      2'd1:    return m_latch & m;
      2'd2:    return m_dir & m;
      default: return m_mode & m;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    case (a)
      2'd1: m_latch = d;
      2'd2: m_dir = d;
      2'd3: m_mode = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    chk(req, rdata0, exp_reg(a, M0));
    chk(req, rdata1, exp_reg(a, M1));
    reg_rd = 1'b0;
    #1;
  endtask

  task automatic pins_chk(input string req);
    #1;
    chk(req, poe0, exp_oe(M0));
    chk(req, pout0, exp_out(M0));
    chk(req, poe1, exp_oe(M1));
    chk(req, pout1, exp_out(M1));
    chk({req, "/R8"}, drv0, m_mode & M0);
    chk({req, "/R8"}, drv1, m_mode & M1);
  endtask

  // new pin level: old value after one edge, new value after two (R3)
  task automatic level_step(input logic [W-1:0] v);
    @(negedge clk);
    pin_in = v;
    @(posedge clk);
    #1;
    rd_chk("R3 level one edge", 2'd0);
    m_pins = v;
    @(posedge clk);
    #1;
    rd_chk("R3 level two edges", 2'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    pin_in = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 oe in reset", poe0, '0);
    chk("R1 out in reset", pout0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    m_pins = 8'hA5;
    #1;
    rd_chk("R1 latch after reset", 2'd1);
    rd_chk("R1 dir after reset", 2'd2);
    rd_chk("R1 mode after reset", 2'd3);
    pins_chk("R1 pins after reset");

    // R9: no strobe, no data
    reg_addr = 2'd0; reg_rd = 1'b0;
    #1;
    chk("R9 idle rdata", rdata0, '0);

    // R2 and R7: full writes read back, dead bits dropped
    wr(2'd1, 8'hFF); rd_chk("R2/R7 latch all ones", 2'd1);
    wr(2'd2, 8'hFF); rd_chk("R2/R7 dir all ones", 2'd2);
    pins_chk("R4 all outputs push-pull");
    wr(2'd3, 8'hFF); rd_chk("R2/R7 mode all ones", 2'd3);
    pins_chk("R6 open drain releases ones");
    wr(2'd1, 8'h00);
    pins_chk("R6 open drain pulls low");

    // R3: writing the level address changes nothing
    wr(2'd0, 8'h3C);
    rd_chk("R3 latch after level write", 2'd1);
    rd_chk("R3 dir after level write", 2'd2);
    rd_chk("R3 mode after level write", 2'd3);
    rd_chk("R3 level after level write", 2'd0);
    pins_chk("R3 pins after level write");

    // R4: external output enable alone turns pins around
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h5A);
    @(negedge clk); pl_oe = 8'h0F;
    pins_chk("R4 ext oe only");

    // R5: override wins, latch still stored
    @(negedge clk); pl_ovr_en = 8'hFF; pl_ovr_data = 8'hC3; pl_oe = 8'hFF;
    pins_chk("R5 override data");
    wr(2'd1, 8'h96);
    rd_chk("R5 latch stored under override", 2'd1);
    pins_chk("R5 latch write no effect");
    @(negedge clk); pl_ovr_en = 8'h00; pl_oe = 8'h00;

    level_step(8'hFF);
    level_step(8'h00);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom % 5;
      if (k == 4) begin
        level_step(8'($urandom));
      end else begin
        wr(2'(k), 8'($urandom));
        @(negedge clk);
        pl_ovr_en = 8'($urandom); pl_ovr_data = 8'($urandom); pl_oe = 8'($urandom);
        pins_chk("R4/R5/R6/R7 random");
        rd_chk("R2/R7 random readback", 2'($urandom));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule